// File: doc/BRIEF.md
# Streaming Address Generator with Circular and Bit-Reversed Modes

This block produces the memory address for each access of a signal-processing loop. Software, or a sequencer, first loads a configuration: a base address, a buffer length, a stride, a direction and a mode. It then pulses a step strobe once per access, and the block presents the next address on a registered output one cycle later. The block does not perform the memory access.

Three sequencing modes share one pointer unit. Linear mode walks the address space by the stride. Circular mode keeps an offset inside a buffer of the configured length and wraps it at either end, so a delay line or sample ring can be walked up or down without software bounds checks. Bit-reversed mode steps an internal index through a power-of-two transform size and emits the index with its bits mirrored, which gives the data reordering an FFT needs without extra instructions or memory accesses. A one-cycle flag marks each wrap of the circular buffer and each completion of a bit-reversed pass.

Top module: `dsp_agu`

## Requirements
- R1: While reset is held, and after it until the first load, `addr_o` is 0 and `wrap_o` is 0.
- R2: A cycle with `cfg_load` high stores the configuration. From the next cycle `addr_o` equals the loaded base, `wrap_o` is 0 and the internal offset and index restart at 0. A load takes priority over a step strobe in the same cycle.
- R3: In a cycle with neither `cfg_load` nor `step`, `addr_o` keeps its value and `wrap_o` is 0 in the next cycle.
- R4: Mode codes on `cfg_mode` are 0 linear, 1 circular and 2 bit-reversed. Code 3 behaves as linear. In linear mode each step adds the stride to the offset (`cfg_dir`=0) or subtracts it (`cfg_dir`=1), modulo 2^AW. The address is base plus offset, modulo 2^AW. `wrap_o` stays 0.
- R5: In circular mode with `cfg_dir`=0, a step moves the offset to offset+stride. When that sum reaches the length or exceeds it, the offset becomes offset+stride-length and `wrap_o` is 1 for that one cycle. The stride need not divide the length.
- R6: In circular mode with `cfg_dir`=1, a step moves the offset to offset-stride. When the stride exceeds the offset, the offset becomes offset+length-stride and `wrap_o` pulses. With stride 1 this takes offset 0 to base+length-1.
- R7: In bit-reversed mode with `cfg_log2n`=n (1 to 10), each step advances an index by one modulo 2^n. The address is base plus the index with its low n bits mirrored. For n=3 the steps after a load give offsets 4, 2, 6, 1, 5, 3, 7, 0. `cfg_dir` and `cfg_stride` have no effect in this mode.
- R8: In bit-reversed mode, the step that returns the index from 2^n-1 to 0 makes `wrap_o` 1 for one cycle, and `addr_o` then equals the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Store configuration and restart the pointer |
| cfg_mode | input | 2 | 0 linear, 1 circular, 2 bit-reversed, 3 linear |
| cfg_dir | input | 1 | 0 increment, 1 decrement (linear and circular) |
| cfg_base | input | AW (16) | Buffer base address |
| cfg_len | input | LEN_W (11) | Circular buffer length in elements |
| cfg_stride | input | LEN_W (11) | Step size magnitude |
| cfg_log2n | input | LOG2_W (4) | log2 of the bit-reversed transform size |
| step | input | 1 | Advance to the next address |
| addr_o | output | AW (16) | Registered current address |
| wrap_o | output | 1 | One-cycle pulse on a circular wrap or the end of a bit-reversed pass |

## Verification
The assertions assume that any circular configuration has a length of at least 1 and a stride below the length. They also assume that a bit-reversed configuration uses a `cfg_log2n` between 1 and 10. Both are legal-use rules of the block and it does not check them. The bench therefore draws the length from 1 to 200, then draws the stride from 0 to length-1, and draws the transform size from 1 to 10. It randomises the mode, the direction, the base, and the timing of the step and load strobes, including loads that arrive together with a step. Directed cases cover the 8-point reversed order, the downward wrap from offset 0, and idle cycles.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_LINEAR = 2'd0,
    MODE_CIRC   = 2'd1,
    MODE_BREV   = 2'd2
  } agu_mode_e;
endpackage

// File: rtl/agu_circ_next.sv
// Next offset inside a circular buffer; one compare-and-correct per step.
module agu_circ_next #(
  parameter int LEN_W = 11
) (
  input  logic [LEN_W-1:0] off_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] stride_i,
  input  logic             dec_i,
  output logic [LEN_W-1:0] off_o,
  output logic             wrap_o
);
  logic [LEN_W:0] sum_up;

  assign sum_up = {1'b0, off_i} + {1'b0, stride_i};

  always_comb begin
    off_o  = off_i;
    wrap_o = 1'b0;
    if (!dec_i) begin
      if (sum_up >= {1'b0, len_i}) begin
        off_o  = LEN_W'(sum_up - {1'b0, len_i});
        wrap_o = 1'b1;
      end else begin
        off_o  = sum_up[LEN_W-1:0];
      end
    end else begin
      if (off_i < stride_i) begin
        off_o  = off_i + len_i - stride_i;
        wrap_o = 1'b1;
      end else begin
        off_o  = off_i - stride_i;
      end
    end
  end
endmodule

// File: rtl/agu_brev_map.sv
// Mirrors the low nbits_i bits of the index; upper bits are cleared.
module agu_brev_map #(
  parameter int LOG2_MAX = 10,
  parameter int LOG2_W   = 4
) (
  input  logic [LOG2_MAX-1:0] idx_i,
  input  logic [LOG2_W-1:0]   nbits_i,
  output logic [LOG2_MAX-1:0] rev_o
);
  logic [LOG2_MAX:1][LOG2_MAX-1:0] rev_tab;

  for (genvar k = 1; k <= LOG2_MAX; k++) begin : g_size
    for (genvar j = 0; j < LOG2_MAX; j++) begin : g_bit
      if (j < k) begin : g_on
        assign rev_tab[k][j] = idx_i[k-1-j];
      end else begin : g_off
        assign rev_tab[k][j] = 1'b0;
      end
    end
  end

  always_comb begin
    rev_o = '0;
    for (int k = 1; k <= LOG2_MAX; k++) begin
      if (32'(nbits_i) == k) rev_o = rev_tab[k];
    end
  end
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
  import agu_pkg::*;
#(
  parameter int AW       = 16,
  parameter int LEN_W    = 11,
  parameter int LOG2_MAX = 10,
  parameter int LOG2_W   = $clog2(LOG2_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_dir,
  input  logic [AW-1:0]     cfg_base,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [LEN_W-1:0]  cfg_stride,
  input  logic [LOG2_W-1:0] cfg_log2n,
  input  logic              step,
  output logic [AW-1:0]     addr_o,
  output logic              wrap_o
);
  localparam int CNT_W = LOG2_MAX;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  // configuration registers
  agu_mode_e         mode_q;
  logic              dir_q;
  logic [AW-1:0]     base_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  stride_q;
  logic [LOG2_W-1:0] log2n_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      mode_q   <= MODE_LINEAR;
      dir_q    <= 1'b0;
      base_q   <= '0;
      len_q    <= LEN_W'(1);
      stride_q <= '0;
      log2n_q  <= LOG2_W'(1);
    end else if (cfg_load) begin
      mode_q   <= agu_mode_e'(cfg_mode);
      dir_q    <= cfg_dir;
      base_q   <= cfg_base;
      len_q    <= cfg_len;
      stride_q <= cfg_stride;
      log2n_q  <= cfg_log2n;
    end
  end

  // pointer state
  logic [AW-1:0]    off_q, off_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic             wrap_q, wrap_d;
  logic             state_en;

  // circular datapath
  logic [LEN_W-1:0] circ_off;
  logic             circ_wrap;

  agu_circ_next #(.LEN_W(LEN_W)) u_circ (
    .off_i    (off_q[LEN_W-1:0]),
    .len_i    (len_q),
    .stride_i (stride_q),
    .dec_i    (dir_q),
    .off_o    (circ_off),
    .wrap_o   (circ_wrap)
  );

  // bit-reversed index counter
  logic [CNT_W-1:0] cnt_mask;
  logic             cnt_last;
  logic [CNT_W-1:0] cnt_next;
  logic [CNT_W-1:0] rev_idx;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      cnt_mask[i] = (i < 32'(log2n_q));
    end
  end

  assign cnt_last = ((cnt_q & cnt_mask) == cnt_mask);
  assign cnt_next = cnt_last ? '0 : (cnt_q + CNT_W'(1));

  agu_brev_map #(.LOG2_MAX(LOG2_MAX), .LOG2_W(LOG2_W)) u_brev (
    .idx_i   (cnt_next),
    .nbits_i (log2n_q),
    .rev_o   (rev_idx)
  );

  // next state
  always_comb begin
    off_d  = off_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    wrap_d = 1'b0;
    if (cfg_load) begin
      off_d  = '0;
      cnt_d  = '0;
      addr_d = cfg_base;
    end else if (step) begin
      case (mode_q)
        MODE_CIRC: begin
          off_d  = AW'(circ_off);
          wrap_d = circ_wrap;
          addr_d = base_q + off_d;
        end
        MODE_BREV: begin
          cnt_d  = cnt_next;
          wrap_d = cnt_last;
          addr_d = base_q + AW'(rev_idx);
        end
        default: begin
          off_d  = dir_q ? (off_q - AW'(stride_q)) : (off_q + AW'(stride_q));
          addr_d = base_q + off_d;
        end
      endcase
    end
  end

  assign state_en = cfg_load | step;

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      off_q  <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (state_en) begin
      off_q  <= off_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) wrap_q <= 1'b0;
    else         wrap_q <= wrap_d;
  end

  assign addr_o = addr_q;
  assign wrap_o = wrap_q;

  // assertions
  p_load_base_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    cfg_load |=> (addr_o == $past(cfg_base)) && !wrap_o)
    else $error("load did not restart at base");

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (!cfg_load && !step) |=> $stable(addr_o) && !wrap_o)
    else $error("address moved without a step");

  p_linear_nowrap_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_q != MODE_CIRC && mode_q != MODE_BREV) |-> !wrap_o)
    else $error("wrap flag in linear mode");

  p_circ_in_range_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_q == MODE_CIRC) |-> (off_q < AW'(len_q)))
    else $error("circular offset outside buffer");

  p_circ_wrap_dir_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_q == MODE_CIRC && step && !cfg_load && dir_q && off_q == '0 && stride_q == LEN_W'(1))
      |=> wrap_o && (addr_o == base_q + AW'(len_q) - AW'(1)))
    else $error("downward wrap did not land on last element");

  p_brev_wrap_base_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (wrap_o && mode_q == MODE_BREV) |-> (addr_o == base_q))
    else $error("bit-reversed pass did not end at base");
endmodule

// File: tb/test_dsp_agu.sv
`timescale 1ns/1ps
module test_dsp_agu;
  localparam int AW = 16;
  localparam int LEN_W = 11;
  localparam int LOG2_W = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_load;
  logic [1:0]        cfg_mode;
  logic              cfg_dir;
  logic [AW-1:0]     cfg_base;
  logic [LEN_W-1:0]  cfg_len;
  logic [LEN_W-1:0]  cfg_stride;
  logic [LOG2_W-1:0] cfg_log2n;
  logic              step;
  logic [AW-1:0]     addr_o;
  logic              wrap_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  int m_mode, m_dir, m_base, m_len, m_stride, m_log2n;
  int m_off, m_cnt, m_addr, m_wrap;

  always #5 clk = ~clk;

  dsp_agu i_dsp_agu (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_dir(cfg_dir), .cfg_base(cfg_base), .cfg_len(cfg_len),
    .cfg_stride(cfg_stride), .cfg_log2n(cfg_log2n), .step(step),
    .addr_o(addr_o), .wrap_o(wrap_o)
  );

  function automatic int mod16(int x);
    return ((x % 65536) + 65536) % 65536;
  endfunction

  function automatic int bitrev(int v, int n);
    int r = 0;
    for (int i = 0; i < n; i++) if (v[i]) r = r | (1 << (n - 1 - i));
    return r;
  endfunction

  function automatic string tag_of(int mode, int dir);
    if (mode == 1) return dir ? "R6" : "R5";
    if (mode == 2) return "R7";
    return "R4";
  endfunction

  task automatic check(string tag, int exp_addr, int exp_wrap);
    n_chk++;
    if (int'(addr_o) != exp_addr || int'(wrap_o) != exp_wrap) begin
      n_bad++;
      $display("FAIL %s: addr=%h wrap=%0d expected addr=%h wrap=%0d",
               tag, addr_o, wrap_o, exp_addr[15:0], exp_wrap);
    end
  endtask

  // model update for one clock edge
  task automatic model_edge(bit ld, bit st, int mode, int dir, int base,
                            int len, int stride, int log2n);
    m_wrap = 0;
    if (ld) begin
      m_mode = mode; m_dir = dir; m_base = base; m_len = len;
      m_stride = stride; m_log2n = log2n; m_off = 0; m_cnt = 0; m_addr = base;
    end else if (st) begin
      if (m_mode == 1) begin
        if (!m_dir) begin
          if (m_off + m_stride >= m_len) m_wrap = 1;
          m_off = (m_off + m_stride) % m_len;
        end else begin
          if (m_off < m_stride) m_wrap = 1;
          m_off = (m_off + m_len - m_stride) % m_len;
        end
        m_addr = mod16(m_base + m_off);
      end else if (m_mode == 2) begin
        int size = 1 << m_log2n;
        if (m_cnt == size - 1) m_wrap = 1;
        m_cnt = (m_cnt + 1) % size;
        m_addr = mod16(m_base + bitrev(m_cnt, m_log2n));
      end else begin
        m_off = mod16(m_dir ? m_off - m_stride : m_off + m_stride);
        m_addr = mod16(m_base + m_off);
      end
    end
  endtask

  // drive at negedge, clock, compare after the edge
  task automatic cyc(bit ld, bit st, int mode, int dir, int base, int len,
                     int stride, int log2n, string tag);
    cfg_load = ld; step = st; cfg_mode = 2'(mode); cfg_dir = 1'(dir);
    cfg_base = AW'(base); cfg_len = LEN_W'(len); cfg_stride = LEN_W'(stride);
    cfg_log2n = LOG2_W'(log2n);
    @(posedge clk);
    model_edge(ld, st, mode, dir, base, len, stride, log2n);
    #2;
    check(tag, m_addr, m_wrap);
    @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    rst_n = 1'b0; cfg_load = 0; step = 0; cfg_mode = 0; cfg_dir = 0;
    cfg_base = 0; cfg_len = 1; cfg_stride = 0; cfg_log2n = 1;
    m_mode = 0; m_dir = 0; m_base = 0; m_len = 1; m_stride = 0; m_log2n = 1;
    m_off = 0; m_cnt = 0; m_addr = 0; m_wrap = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 0, 0);

    // R7/R8: 8-point reversed order, base 0x100
    cyc(1, 0, 2, 0, 'h100, 1, 0, 3, "R2");
    begin
      int seq[8] = '{4, 2, 6, 1, 5, 3, 7, 0};
      for (int i = 0; i < 8; i++) begin
        cyc(0, 1, 2, 0, 0, 1, 0, 3, (i == 7) ? "R8" : "R7");
        check("R7 literal", 'h100 + seq[i], (i == 7) ? 1 : 0);
      end
    end

    // R6: decrement from offset 0 lands on base+len-1
    cyc(1, 0, 1, 1, 'h40, 5, 1, 1, "R2");
    cyc(0, 1, 0, 0, 0, 1, 0, 1, "R6");
    check("R6 literal", 'h44, 1);

    // R5: stride not dividing length, len 5 stride 3: 3, 1(wrap), 4
    cyc(1, 0, 1, 0, 'h200, 5, 3, 1, "R2");
    cyc(0, 1, 0, 0, 0, 1, 0, 1, "R5");
    check("R5 literal", 'h203, 0);
    cyc(0, 1, 0, 0, 0, 1, 0, 1, "R5");
    check("R5 literal", 'h201, 1);

    // R3: idle cycles hold the address
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, 0, 1, "R3");

    // R2: load with step in the same cycle restarts at base
    cyc(1, 1, 0, 0, 'h1234, 9, 4, 1, "R2");
    check("R2 literal", 'h1234, 0);

    // R4: linear decrement wraps through zero with no flag
    cyc(1, 0, 3, 1, 'h0002, 9, 5, 1, "R2");
    cyc(0, 1, 0, 0, 0, 1, 0, 1, "R4");
    check("R4 literal", 'hFFFD, 0);

    // random phase
    for (int c = 0; c < 400; c++) begin
      int mode = $urandom_range(3);
      int dir = $urandom_range(1);
      int base = $urandom_range(65535);
      int len = $urandom_range(200, 1);
      int stride = $urandom_range(len - 1);
      int log2n = $urandom_range(10, 1);
      int ncyc = $urandom_range(60, 1);
      if (mode == 0 || mode == 3) stride = $urandom_range(2047);
      cyc(1, $urandom_range(1) == 1, mode, dir, base, len, stride, log2n, "R2");
      for (int k = 0; k < ncyc; k++) begin
        bit st = ($urandom_range(3) != 0);
        cyc(0, st, $urandom_range(3), $urandom_range(1), $urandom_range(65535),
            len, stride, log2n, st ? tag_of(m_mode, m_dir) : "R3");
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule